// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block arbitrates load-reserve/store-conditional pairs for a set of requesters that share one memory. Each requester presents one request per cycle carrying an operation code and a byte address. A reserving load records the address granule for that requester. A later conditional store from the same requester may write memory only if the reservation is still intact. The monitor answers every conditional store one cycle later with a status bit: 0 if the store was carried out and 1 if it was refused.

Reservations are cancelled by conflicting writes. These include plain stores and granted conditional stores from other requesters, and writes from an external agent such as another core. The store-permission output `mem_we` is combinational, so the memory can commit a permitted write in the same cycle as the request. Addresses are plain base addresses with no offset or indexing applied. A granule is 2^GRAN_LSB bytes, which is 8 bytes by default.

Top module: `xmon_top`

## Requirements
- R1: After reset no requester holds a reservation. A conditional store is refused, so `mem_we` is 0 and the status is 1.
- R2: A conditional store is performed when it comes after a reserving load from the same requester to the same 8-byte granule, whatever the byte offsets. It is also performed only when no cancelling event came in between. Being performed means `mem_we` is 1 in the request cycle and the status is 0.
- R3: Operation codes are 0 plain load, 1 plain store, 2 reserving load and 3 conditional store. `rsp_valid[i]` is 1 exactly one cycle after a conditional store from requester i, and at no other time. `rsp_fail[i]` then carries the status.
- R4: A conditional store to a granule other than the reserved one is refused and does not write.
- R5: A conditional store clears its requester's reservation, whether or not it is performed.
- R6: A new reserving load replaces the requester's earlier reservation.
- R7: A plain store by another requester to the reserved granule cancels the reservation. A plain store by the owner to its own granule does not.
- R8: An external write (`ext_wr_valid`) to the reserved granule cancels the reservation.
- R9: Writes to other granules leave a reservation in place.
- R10: When several conditional stores that would each pass target one granule in the same cycle, only the lowest-numbered requester is performed. The others are refused. Passing stores to different granules are all performed.
- R11: A conditional store is refused if, in the same cycle, another requester's plain store or an external write targets its granule.
- R12: A plain store always asserts `mem_we`. Plain and reserving loads never do.
- R13: A reserving load made in the same cycle as another agent's write to the same granule still establishes the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Request present, one bit per requester |
| req_op | input | N x 2 | Operation code per requester |
| req_addr | input | N x AW | Byte address per requester |
| ext_wr_valid | input | 1 | External agent writes memory this cycle |
| ext_wr_addr | input | AW | Byte address of the external write |
| mem_we | output | N | Write to memory permitted this cycle |
| rsp_valid | output | N | Conditional-store status is valid |
| rsp_fail | output | N | Status: 0 performed, 1 refused |

## Verification
The bench targets same-cycle collisions. In one case two requesters pass on one granule together; a broken arbiter would let both write. In another a plain or external write lands in the same cycle as the conditional store; a wrong design would let the stale store through. Granule aliasing is checked with differing byte offsets inside the granule and adjacent granules just outside it. A design that compared full addresses, or masked too few bits, would then fail or pass the wrong way. Further cases check that the owner's own store keeps its reservation, that a failed store still clears it, and that a reserving load racing a foreign write wins. Each of these cases shows up as a wrong `mem_we` or a wrong status bit.

// File: rtl/xmon_pkg.sv
package xmon_pkg;

    typedef enum logic [1:0] {
        XOP_LOAD  = 2'd0,
        XOP_STORE = 2'd1,
        XOP_LDEX  = 2'd2,
        XOP_STEX  = 2'd3
    } xop_e;

    typedef struct packed {
        logic vld;
        logic fail;
    } xrsp_t;

    function automatic logic op_is(input logic v, input logic [1:0] op, input xop_e kind);
        return v && (xop_e'(op) == kind);
    endfunction

endpackage

// File: rtl/xmon_slot.sv
module xmon_slot #(
    parameter int N   = 4,
    parameter int GW  = 29,
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 own_ldex,
    input  logic                 own_stex,
    input  logic [GW-1:0]        own_gran,
    input  logic [N-1:0][GW-1:0] wr_gran,
    input  logic [N-1:0]         plain_wr,
    input  logic [N-1:0]         stex_wr,
    input  logic                 ext_vld,
    input  logic [GW-1:0]        ext_gran,
    output logic                 stex_ok
);

    typedef struct packed {
        logic          vld;
        logic [GW-1:0] gran;
    } resv_t;

    resv_t resv_q, resv_d;
    logic  same_cycle_hit;
    logic  kill;

    always_comb begin
        same_cycle_hit = ext_vld && (ext_gran == own_gran);
        kill           = ext_vld && (ext_gran == resv_q.gran);
        for (int j = 0; j < N; j++) begin
            if (j != IDX) begin
                if (plain_wr[j] && (wr_gran[j] == own_gran))
                    same_cycle_hit = 1'b1;
                if ((plain_wr[j] || stex_wr[j]) && (wr_gran[j] == resv_q.gran))
                    kill = 1'b1;
            end
        end
    end

    assign stex_ok = own_stex && resv_q.vld && (resv_q.gran == own_gran) && !same_cycle_hit;

    always_comb begin
        resv_d = resv_q;
        if (own_ldex) begin
            resv_d.vld  = 1'b1;
            resv_d.gran = own_gran;
        end else if (own_stex) begin
            resv_d.vld = 1'b0;
        end else if (kill) begin
            resv_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_d;
        end
    end

endmodule

// File: rtl/xmon_arbiter.sv
module xmon_arbiter #(
    parameter int N  = 4,
    parameter int GW = 29
) (
    input  logic [N-1:0]         ok,
    input  logic [N-1:0][GW-1:0] gran,
    output logic [N-1:0]         grant
);

    for (genvar i = 0; i < N; i++) begin : g_req
        logic blocked;
        always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (ok[j] && (gran[j] == gran[i]))
                    blocked = 1'b1;
            end
        end
        assign grant[i] = ok[i] && !blocked;
    end

endmodule

// File: rtl/xmon_resp.sv
module xmon_resp
    import xmon_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] stex,
    input  logic [N-1:0] grant,
    output logic [N-1:0] rsp_valid,
    output logic [N-1:0] rsp_fail
);

    xrsp_t [N-1:0] rsp_q;

    for (genvar i = 0; i < N; i++) begin : g_rsp
        always_ff @(posedge clk) begin
            if (rst) begin
                rsp_q[i] <= '0;
            end else begin
                rsp_q[i].vld  <= stex[i];
                rsp_q[i].fail <= stex[i] && !grant[i];
            end
        end
        assign rsp_valid[i] = rsp_q[i].vld;
        assign rsp_fail[i]  = rsp_q[i].fail;
    end

endmodule

// File: rtl/xmon_top.sv
module xmon_top
    import xmon_pkg::*;
#(
    parameter int N        = 4,
    parameter int AW       = 32,
    parameter int GRAN_LSB = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req_valid,
    input  logic [N-1:0][1:0]    req_op,
    input  logic [N-1:0][AW-1:0] req_addr,
    input  logic                 ext_wr_valid,
    input  logic [AW-1:0]        ext_wr_addr,
    output logic [N-1:0]         mem_we,
    output logic [N-1:0]         rsp_valid,
    output logic [N-1:0]         rsp_fail
);

    localparam int GW = AW - GRAN_LSB;

    logic [N-1:0][GW-1:0] gran;
    logic [GW-1:0]        ext_gran;
    logic [N-1:0]         is_st, is_ldex, is_stex;
    logic [N-1:0]         stex_ok, grant;
    logic                 unused_lo;

    always_comb begin
        unused_lo = ^ext_wr_addr[GRAN_LSB-1:0];
        for (int i = 0; i < N; i++)
            unused_lo = unused_lo ^ (^req_addr[i][GRAN_LSB-1:0]);
    end

    assign ext_gran = ext_wr_addr[AW-1:GRAN_LSB];

    for (genvar i = 0; i < N; i++) begin : g_dec
        assign gran[i]    = req_addr[i][AW-1:GRAN_LSB];
        assign is_st[i]   = op_is(req_valid[i], req_op[i], XOP_STORE);
        assign is_ldex[i] = op_is(req_valid[i], req_op[i], XOP_LDEX);
        assign is_stex[i] = op_is(req_valid[i], req_op[i], XOP_STEX);
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        xmon_slot #(.N(N), .GW(GW), .IDX(i)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .own_ldex (is_ldex[i]),
            .own_stex (is_stex[i]),
            .own_gran (gran[i]),
            .wr_gran  (gran),
            .plain_wr (is_st),
            .stex_wr  (grant),
            .ext_vld  (ext_wr_valid),
            .ext_gran (ext_gran),
            .stex_ok  (stex_ok[i])
        );
    end

    xmon_arbiter #(.N(N), .GW(GW)) u_arb (
        .ok    (stex_ok),
        .gran  (gran),
        .grant (grant)
    );

    xmon_resp #(.N(N)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .stex      (is_stex),
        .grant     (grant),
        .rsp_valid (rsp_valid),
        .rsp_fail  (rsp_fail)
    );

    assign mem_we = is_st | grant;

endmodule

// File: rtl/xmon_checker.sv
module xmon_checker #(
    parameter int N        = 4,
    parameter int AW       = 32,
    parameter int GRAN_LSB = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N-1:0]         req_valid,
    input logic [N-1:0][1:0]    req_op,
    input logic [N-1:0][AW-1:0] req_addr,
    input logic [N-1:0]         mem_we,
    input logic [N-1:0]         rsp_valid,
    input logic [N-1:0]         rsp_fail
);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R3
        stex_rsp_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid[i] && req_op[i] == 2'd3) |=> rsp_valid[i]);
        // R3
        no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
            !(req_valid[i] && req_op[i] == 2'd3) |=> !rsp_valid[i]);
        // R2
        pass_status_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid[i] && req_op[i] == 2'd3 && mem_we[i]) |=> !rsp_fail[i]);
        // R12
        store_we_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid[i] && req_op[i] == 2'd1) |-> mem_we[i]);
        // R12
        load_no_we_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid[i] && req_op[i][1] == 1'b0 && req_op[i][0] == 1'b0) |-> !mem_we[i]);
        // R12
        ldex_no_we_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid[i] && req_op[i] == 2'd2) |-> !mem_we[i]);
        // R3
        fail_only_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
            rsp_fail[i] |-> rsp_valid[i]);
        for (genvar j = i + 1; j < N; j++) begin : g_pair
            // R10
            single_winner_chk: assert property (@(posedge clk) disable iff (rst)
                !(req_valid[i] && req_valid[j] && req_op[i] == 2'd3 && req_op[j] == 2'd3 &&
                  req_addr[i][AW-1:GRAN_LSB] == req_addr[j][AW-1:GRAN_LSB] &&
                  mem_we[i] && mem_we[j]));
        end
    end

endmodule

bind xmon_top xmon_checker #(.N(N), .AW(AW), .GRAN_LSB(GRAN_LSB)) u_xmon_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .mem_we    (mem_we),
    .rsp_valid (rsp_valid),
    .rsp_fail  (rsp_fail)
);

// File: tb/xmon_top_bench.sv
`timescale 1ns/1ps
module xmon_top_bench;

    localparam int N  = 4;
    localparam int AW = 32;
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, LX = 2'd2, SX = 2'd3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [N-1:0]         req_valid = '0;
    logic [N-1:0][1:0]    req_op = '0;
    logic [N-1:0][AW-1:0] req_addr = '0;
    logic                 ext_wr_valid = 1'b0;
    logic [AW-1:0]        ext_wr_addr = '0;
    logic [N-1:0]         mem_we, rsp_valid, rsp_fail;
    logic [N-1:0]         we_s, rv_s, rf_s;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    xmon_top #(.N(N), .AW(AW), .GRAN_LSB(3)) u_xmon_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .ext_wr_valid(ext_wr_valid), .ext_wr_addr(ext_wr_addr),
        .mem_we(mem_we), .rsp_valid(rsp_valid), .rsp_fail(rsp_fail)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic stage(input int i, input logic [1:0] op, input logic [AW-1:0] a);
        req_valid[i] = 1'b1;
        req_op[i]    = op;
        req_addr[i]  = a;
    endtask

    task automatic stage_ext(input logic [AW-1:0] a);
        ext_wr_valid = 1'b1;
        ext_wr_addr  = a;
    endtask

    // Called at a falling edge: applies staged inputs for one cycle.
    task automatic run_cycle();
        #1;
        we_s = mem_we;
        @(negedge clk);
        rv_s = rsp_valid;
        rf_s = rsp_fail;
        req_valid    = '0;
        ext_wr_valid = 1'b0;
    endtask

    task automatic one(input int i, input logic [1:0] op, input logic [AW-1:0] a);
        stage(i, op, a);
        run_cycle();
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R1 mem_we idle", 32'(mem_we), 0);
        one(0, SX, 32'h40);
        chk("R1 stex no write", 32'(we_s[0]), 0);
        chk("R1 stex fails", 32'(rf_s[0]), 1);
        chk("R3 rsp valid after stex", 32'(rv_s), 32'h1);
    endtask

    task automatic t_basic();
        one(1, LX, 32'h100);
        chk("R3 no rsp for ldex", 32'(rv_s), 0);
        one(1, SX, 32'h104);
        chk("R2 stex writes", 32'(we_s[1]), 1);
        chk("R2 stex status", 32'(rf_s[1]), 0);
        chk("R3 rsp valid", 32'(rv_s[1]), 1);
        one(1, SX, 32'h100);
        chk("R5 second stex fails", 32'(rf_s[1]), 1);
        chk("R5 second stex no write", 32'(we_s[1]), 0);
    endtask

    task automatic t_mismatch();
        one(2, LX, 32'h200);
        one(2, SX, 32'h208);
        chk("R4 wrong granule no write", 32'(we_s[2]), 0);
        chk("R4 wrong granule fails", 32'(rf_s[2]), 1);
        one(2, SX, 32'h200);
        chk("R5 cleared after failed stex", 32'(rf_s[2]), 1);
    endtask

    task automatic t_replace();
        one(0, LX, 32'h300);
        one(0, LX, 32'h400);
        one(0, SX, 32'h300);
        chk("R6 old reservation gone", 32'(rf_s[0]), 1);
        one(0, LX, 32'h300);
        one(0, LX, 32'h400);
        one(0, SX, 32'h407);
        chk("R6 new reservation holds", 32'(rf_s[0]), 0);
    endtask

    task automatic t_stores();
        one(0, LX, 32'h500);
        one(1, ST, 32'h506);
        chk("R12 plain store writes", 32'(we_s[1]), 1);
        chk("R3 no rsp for store", 32'(rv_s), 0);
        one(0, SX, 32'h500);
        chk("R7 foreign store cancels", 32'(rf_s[0]), 1);
        one(0, LX, 32'h500);
        one(0, ST, 32'h500);
        one(0, LD, 32'h500);
        chk("R12 load no write", 32'(we_s[0]), 0);
        chk("R3 no rsp for load", 32'(rv_s), 0);
        one(0, SX, 32'h501);
        chk("R7 own store keeps reservation", 32'(rf_s[0]), 0);
    endtask

    task automatic t_ext();
        one(3, LX, 32'h600);
        stage_ext(32'h603);
        run_cycle();
        one(3, SX, 32'h600);
        chk("R8 external write cancels", 32'(rf_s[3]), 1);
        one(3, LX, 32'h600);
        stage_ext(32'h608);
        run_cycle();
        one(1, ST, 32'h5F8);
        one(3, SX, 32'h600);
        chk("R9 neighbouring writes keep reservation", 32'(rf_s[3]), 0);
        chk("R9 stex writes", 32'(we_s[3]), 1);
    endtask

    task automatic t_race();
        stage(1, LX, 32'h800);
        stage(2, LX, 32'h804);
        run_cycle();
        stage(1, SX, 32'h800);
        stage(2, SX, 32'h802);
        run_cycle();
        chk("R10 winner write", 32'(we_s[1]), 1);
        chk("R10 loser no write", 32'(we_s[2]), 0);
        chk("R10 statuses", 32'(rf_s), 32'h4);
        stage(0, LX, 32'h880);
        stage(3, LX, 32'h890);
        run_cycle();
        stage(0, SX, 32'h880);
        stage(3, SX, 32'h890);
        run_cycle();
        chk("R10 distinct granules both write", 32'(we_s), 32'h9);
        chk("R10 distinct granules both pass", 32'(rf_s), 0);
    endtask

    task automatic t_same_cycle();
        one(0, LX, 32'h900);
        stage(0, SX, 32'h900);
        stage(1, ST, 32'h904);
        run_cycle();
        chk("R11 concurrent store refuses stex", 32'(we_s), 32'h2);
        chk("R11 status", 32'(rf_s[0]), 1);
        one(2, LX, 32'h980);
        stage(2, SX, 32'h980);
        stage_ext(32'h987);
        run_cycle();
        chk("R11 concurrent external write refuses stex", 32'(rf_s[2]), 1);
        stage(0, LX, 32'hA00);
        stage(1, ST, 32'hA00);
        run_cycle();
        one(0, SX, 32'hA00);
        chk("R13 racing ldex keeps reservation", 32'(rf_s[0]), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mismatch();
        t_replace();
        t_stores();
        t_ext();
        t_race();
        t_same_cycle();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule